// File: doc/BRIEF.md
# Chained Receive Queue Controller

This block keeps track of up to two receive requests that a host has queued ahead of a packet receive engine. Each "arm receive" command carries a buffer page number and joins a two-slot queue. The oldest slot is the head. Its page is shown on `active_page`, and that slot waits for the engine to report the start of a packet. When the engine reports that the packet has finished, the head slot is retired and the next slot becomes the head. The next slot then waits for the next packet, exactly as if its command had just been issued.

Completed receptions are reported through a status bit with double buffering. A result that finishes while an earlier result is still unacknowledged is held back. The held result is shown only after the host's acknowledge command, and only after the status bit has stayed low for a set number of clock cycles. A mask input gates only the interrupt line, never the status bit. A cancel command removes the oldest queued request, but only if that request has not begun.

The queue runs as a five-state machine: `Q_EMPTY`, `Q_ONE_WAIT`, `Q_ONE_BUSY`, `Q_TWO_WAIT` and `Q_TWO_BUSY`. Its transitions are arm (push), start (WAIT to BUSY), finish (BUSY to the next WAIT or to empty) and cancel (WAIT to one fewer entry). The status logic runs as a four-state machine: `S_IDLE`, `S_FLAG`, `S_FLAG_HELD` and `S_GAP`. Its transitions are finish (IDLE to FLAG, or FLAG to FLAG_HELD), acknowledge (FLAG or FLAG_HELD to GAP) and gap expiry (GAP to FLAG if a result is held, otherwise GAP to IDLE).

Top module: `rxq_chain_ctrl`

## Requirements
- R1: An `arm_rx` pulse stores `arm_page` in the queue when fewer than two requests are held. `active_page` shows the oldest held page, or zero when the queue is empty. `queue_empty` is 1 exactly when no request is held.
- R2: An `arm_rx` pulse that arrives while two requests are held is ignored. It sets `arm_overflow`, which then stays at 1 until reset.
- R3: `rx_begin` marks the head request as begun only if that request is still waiting. `rx_end` counts as a completion only if the head has begun. A completion retires the head, and the next request then waits for its own `rx_begin`.
- R4: `cancel_rx` removes the head request only if the head has not begun, and has no effect once the head has begun. If `cancel_rx` and `rx_begin` arrive in the same cycle, the cancel wins. Two cancels empty a queue that holds two waiting requests.
- R5: After reset, `rx_status` is 0. The status bit becomes 1 only as the result of a completion.
- R6: Once set, `rx_status` stays at 1 until an `ack_rx` pulse arrives. It then falls in the next cycle. An `ack_rx` pulse while the status bit is 0 has no effect.
- R7: If a completion happens while `rx_status` is 1, including in the same cycle as the `ack_rx`, its result is held. The held result is shown after the acknowledge and the gap.
- R8: After an acknowledge, `rx_status` stays at 0 for exactly `GAP_CYC` cycles (5 by default). It then rises if a result is held or if a completion arrived during the gap. Otherwise it stays at 0.
- R9: `rx_irq` equals `rx_status` when `rx_inhibit` is 0 and is 0 when `rx_inhibit` is 1. `rx_inhibit` never changes `rx_status`.
- R10: At most one result can be held. A further completion while a result is already held merges with it, so one acknowledge and one gap bring the status back only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_rx | input | 1 | Command pulse: queue a receive request |
| arm_page | input | PAGE_W | Buffer page for the queued request |
| cancel_rx | input | 1 | Command pulse: cancel the oldest request that has not begun |
| ack_rx | input | 1 | Command pulse: acknowledge the reported reception |
| rx_begin | input | 1 | Engine pulse: a packet has started into the head page |
| rx_end | input | 1 | Engine pulse: the packet has finished |
| rx_inhibit | input | 1 | Mask bit for the receive interrupt |
| active_page | output | PAGE_W | Page of the head request, 0 when the queue is empty |
| queue_empty | output | 1 | No request is held |
| rx_status | output | 1 | Receive-complete status bit |
| rx_irq | output | 1 | Receive interrupt after masking |
| arm_overflow | output | 1 | Sticky flag: an arm command arrived while the queue was full |

## Verification
On every cycle, the assertions check the following:
- the status bit falls only after an acknowledge;
- the status bit rises only after a completion or at the end of a gap;
- the low time before every rise after the first is at least the gap length;
- the interrupt is never high without the status bit;
- the overflow flag, once set, stays set;
- a cancel against a request that has begun leaves the head page in place.

Some behaviours are shown only by the bench's scenarios, checked against its reference model:
- the order in which pages move through the queue;
- the exact cycle in which a held result appears;
- merging of a third completion;
- the same-cycle collisions of cancel with begin and of acknowledge with completion.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [2:0] {
        Q_EMPTY,
        Q_ONE_WAIT,
        Q_ONE_BUSY,
        Q_TWO_WAIT,
        Q_TWO_BUSY
    } q_state_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FLAG,
        S_FLAG_HELD,
        S_GAP
    } s_state_e;

endpackage

// File: rtl/rxq_slot_queue.sv
module rxq_slot_queue
    import rxq_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              cancel_i,
    input  logic              begin_i,
    input  logic              end_i,
    output logic [PAGE_W-1:0] head_page_o,
    output logic              empty_o,
    output logic              overflow_o,
    output logic              complete_o
);

    localparam logic [1:0] DEPTH = 2'd2;

    q_state_e          state_q, state_d;
    logic [1:0]        cnt, cnt_mid, cnt_n;
    logic              busy, busy_n;
    logic              pop, start, push;
    logic [PAGE_W-1:0] slot0_q, slot1_q;

    // Decode the current state into an occupancy count and a begun flag.
    always_comb begin
        unique case (state_q)
            Q_EMPTY:    begin cnt = 2'd0; busy = 1'b0; end
            Q_ONE_WAIT: begin cnt = 2'd1; busy = 1'b0; end
            Q_ONE_BUSY: begin cnt = 2'd1; busy = 1'b1; end
            Q_TWO_WAIT: begin cnt = 2'd2; busy = 1'b0; end
            Q_TWO_BUSY: begin cnt = 2'd2; busy = 1'b1; end
            default:    begin cnt = 2'd0; busy = 1'b0; end
        endcase
    end

    // Transition events: finish, cancel, start and arm.
    always_comb begin
        complete_o = end_i && busy;
        pop        = complete_o || (cancel_i && !busy && (cnt != 2'd0));
        start      = begin_i && !busy && (cnt != 2'd0) && !cancel_i;
        push       = arm_i && (cnt != DEPTH);
        cnt_mid    = cnt - {1'b0, pop};
        cnt_n      = cnt_mid + {1'b0, push};
        busy_n     = start ? 1'b1 : (pop ? 1'b0 : busy);
        unique case ({cnt_n, busy_n})
            3'b010:  state_d = Q_ONE_WAIT;
            3'b011:  state_d = Q_ONE_BUSY;
            3'b100:  state_d = Q_TWO_WAIT;
            3'b101:  state_d = Q_TWO_BUSY;
            default: state_d = Q_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // Page slots and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot0_q    <= '0;
            slot1_q    <= '0;
            overflow_o <= 1'b0;
        end else begin
            if (pop) slot0_q <= slot1_q;
            if (push) begin
                if (cnt_mid == 2'd0) slot0_q <= page_i;
                else                 slot1_q <= page_i;
            end
            if (arm_i && (cnt == DEPTH)) overflow_o <= 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        empty_o     = (state_q == Q_EMPTY);
        head_page_o = empty_o ? '0 : slot0_q;
    end

    // R2
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    // R2
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> $past(arm_i));

    // R4
    cancel_begun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_i && busy && !end_i) |=> (!empty_o && $stable(head_page_o)));

endmodule

// File: rtl/rxq_status_fsm.sv
module rxq_status_fsm
    import rxq_pkg::*;
#(
    parameter int GAP_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic complete_i,
    input  logic ack_i,
    output logic status_o
);

    localparam int CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC + 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);

    s_state_e      state_q, state_d;
    logic          held_q, held_d;
    logic [CW-1:0] gap_q;
    logic          gap_done;

    always_comb begin
        gap_done = (gap_q == GAP_LAST);
        state_d  = state_q;
        held_d   = held_q;
        unique case (state_q)
            S_IDLE: begin
                if (complete_i) state_d = S_FLAG;
            end
            S_FLAG: begin
                if (ack_i) begin
                    state_d = S_GAP;
                    held_d  = complete_i;
                end else if (complete_i) begin
                    state_d = S_FLAG_HELD;
                end
            end
            S_FLAG_HELD: begin
                if (ack_i) begin
                    state_d = S_GAP;
                    held_d  = 1'b1;
                end
            end
            S_GAP: begin
                if (complete_i) held_d = 1'b1;
                if (gap_done) begin
                    state_d = (held_q || complete_i) ? S_FLAG : S_IDLE;
                    held_d  = 1'b0;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register, together with the held flag and the gap counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            held_q  <= 1'b0;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
            if (state_q != S_GAP) gap_q <= '0;
            else                  gap_q <= gap_q + 1'b1;
        end
    end

    // Output.
    always_comb begin
        status_o = (state_q == S_FLAG) || (state_q == S_FLAG_HELD);
    end

    // Gap watcher: counts how long the status bit has been low.
    logic [CW:0] low_run;
    logic        seen_high;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run   <= '0;
            seen_high <= 1'b0;
        end else if (status_o) begin
            low_run   <= '0;
            seen_high <= 1'b1;
        end else if (low_run != (CW+1)'(GAP_CYC)) begin
            low_run <= low_run + 1'b1;
        end
    end

    // R8
    gap_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status_o) && seen_high) |-> (low_run >= (CW+1)'(GAP_CYC)));

    // R6
    clear_only_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o) |-> $past(ack_i));

    // R5
    set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o) |-> ($past(complete_i) || $past(state_q == S_GAP)));

endmodule

// File: rtl/rxq_chain_ctrl.sv
module rxq_chain_ctrl #(
    parameter int PAGE_W  = 4,
    parameter int GAP_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_rx,
    input  logic [PAGE_W-1:0] arm_page,
    input  logic              cancel_rx,
    input  logic              ack_rx,
    input  logic              rx_begin,
    input  logic              rx_end,
    input  logic              rx_inhibit,
    output logic [PAGE_W-1:0] active_page,
    output logic              queue_empty,
    output logic              rx_status,
    output logic              rx_irq,
    output logic              arm_overflow
);

    logic complete;

    rxq_slot_queue #(.PAGE_W(PAGE_W)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm_rx),
        .page_i      (arm_page),
        .cancel_i    (cancel_rx),
        .begin_i     (rx_begin),
        .end_i       (rx_end),
        .head_page_o (active_page),
        .empty_o     (queue_empty),
        .overflow_o  (arm_overflow),
        .complete_o  (complete)
    );

    rxq_status_fsm #(.GAP_CYC(GAP_CYC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .complete_i (complete),
        .ack_i      (ack_rx),
        .status_o   (rx_status)
    );

    always_comb rx_irq = rx_status && !rx_inhibit;

    // R9
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_status);

endmodule

// File: tb/rxq_chain_ctrl_test.sv
`timescale 1ns/1ps
module rxq_chain_ctrl_test;

    localparam int PW  = 4;
    localparam int GAP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_rx = 0, cancel_rx = 0, ack_rx = 0, rx_begin = 0, rx_end = 0, rx_inhibit = 0;
    logic [PW-1:0] arm_page = '0;
    logic [PW-1:0] active_page;
    logic          queue_empty, rx_status, rx_irq, arm_overflow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    rxq_chain_ctrl #(.PAGE_W(PW), .GAP_CYC(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .arm_rx(arm_rx), .arm_page(arm_page),
        .cancel_rx(cancel_rx), .ack_rx(ack_rx), .rx_begin(rx_begin), .rx_end(rx_end),
        .rx_inhibit(rx_inhibit), .active_page(active_page), .queue_empty(queue_empty),
        .rx_status(rx_status), .rx_irq(rx_irq), .arm_overflow(arm_overflow)
    );

    always #10 clk = ~clk;

    // Behavioural reference model.
    int      m_count = 0;
    bit      m_begun = 0;
    int      m_pages[$];
    bit      m_ovf = 0;
    bit      m_shown = 0;
    bit      m_held = 0;
    int      m_gap = 0;

    always @(posedge clk) begin
        bit fin;
        bit drop;
        bit go;
        if (!rst_n) begin
            m_count = 0; m_begun = 0; m_pages.delete(); m_ovf = 0;
            m_shown = 0; m_held = 0; m_gap = 0;
        end else begin
            fin  = rx_end && m_begun;
            drop = fin || (cancel_rx && !m_begun && m_count > 0);
            go   = rx_begin && !m_begun && m_count > 0 && !cancel_rx;
            if (arm_rx && m_count == 2) m_ovf = 1;
            if (drop) begin void'(m_pages.pop_front()); m_count--; m_begun = 0; end
            if (go) m_begun = 1;
            if (arm_rx && m_pages.size() < 2 && (m_count + (drop ? 1 : 0)) < 2) begin
                m_pages.push_back(int'(arm_page)); m_count++;
            end
            if (m_gap > 0) begin
                if (fin) m_held = 1;
                m_gap--;
                if (m_gap == 0) begin m_shown = m_held; m_held = 0; end
            end else if (m_shown && ack_rx) begin
                m_shown = 0; m_gap = GAP;
                if (fin) m_held = 1;
            end else if (fin) begin
                if (m_shown) m_held = 1;
                else         m_shown = 1;
            end
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        #2;
        check_eq("R1 active_page", int'(active_page), (m_count > 0) ? m_pages[0] : 0);
        check_eq("R1 queue_empty", int'(queue_empty), (m_count == 0) ? 1 : 0);
        check_eq("R2 arm_overflow", int'(arm_overflow), int'(m_ovf));
        check_eq("R5/R6/R7/R8/R10 rx_status", int'(rx_status), int'(m_shown));
        check_eq("R9 rx_irq", int'(rx_irq), (m_shown && !rx_inhibit) ? 1 : 0);
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            errors++;
            $display("FAIL R3 watchdog: cycles %0d expected below 5000", cyc);
            finish_run();
        end
    end

    task automatic step(input logic a, input logic [PW-1:0] p, input logic c,
                        input logic b, input logic e, input logic k);
        arm_rx = a; arm_page = p; cancel_rx = c; rx_begin = b; rx_end = e; ack_rx = k;
        @(negedge clk);
        arm_rx = 0; cancel_rx = 0; rx_begin = 0; rx_end = 0; ack_rx = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        check_eq("R5 reset status", int'(rx_status), 0);
        rst_n = 1;
        idle(1);
        // R1 / R2: fill, then overflow
        step(1, 4'd3, 0, 0, 0, 0);
        step(1, 4'd9, 0, 0, 0, 0);
        step(1, 4'd5, 0, 0, 0, 0);
        check_eq("R2 overflow set", int'(arm_overflow), 1);
        check_eq("R1 head page", int'(active_page), 3);
        // R3: end before begin ignored, then begin/end first
        step(0, 0, 0, 0, 1, 0);
        check_eq("R3 end without begin", int'(rx_status), 0);
        step(0, 0, 0, 1, 0, 0);
        idle(2);
        step(0, 0, 0, 0, 1, 0);
        check_eq("R3 next head", int'(active_page), 9);
        check_eq("R5 status after completion", int'(rx_status), 1);
        // R7: second completes before ack
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        idle(3);
        // R9: mask
        rx_inhibit = 1;
        idle(3);
        check_eq("R9 status kept under mask", int'(rx_status), 1);
        rx_inhibit = 0;
        // R6 / R8: ack then gap
        step(0, 0, 0, 0, 0, 1);
        check_eq("R6 status falls", int'(rx_status), 0);
        idle(GAP - 1);
        check_eq("R8 still low in gap", int'(rx_status), 0);
        idle(1);
        check_eq("R7 held shown", int'(rx_status), 1);
        step(0, 0, 0, 0, 0, 1);
        idle(GAP + 3);
        check_eq("R8 no held result", int'(rx_status), 0);
        step(0, 0, 0, 0, 0, 1);
        idle(2);
        // R4: cancel cases
        step(1, 4'd1, 0, 0, 0, 0);
        step(1, 4'd2, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        check_eq("R4 cancel waiting head", int'(active_page), 2);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        check_eq("R4 cancel of begun ignored", int'(active_page), 2);
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 1);
        idle(GAP + 2);
        step(1, 4'd7, 0, 0, 0, 0);
        step(1, 4'd8, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        check_eq("R4 two cancels empty", int'(queue_empty), 1);
        // R10: third completion merges
        for (int j = 1; j <= 3; j++) begin
            step(1, 4'(j), 0, 0, 0, 0);
            step(0, 0, 0, 1, 0, 0);
            step(0, 0, 0, 0, 1, 0);
        end
        step(0, 0, 0, 0, 0, 1);
        idle(GAP + 2);
        check_eq("R10 held shown once", int'(rx_status), 1);
        step(0, 0, 0, 0, 0, 1);
        idle(GAP + 2);
        check_eq("R10 merged result gone", int'(rx_status), 0);
        // R7: ack and completion in the same cycle
        step(1, 4'd4, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        step(1, 4'd5, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 1);
        idle(GAP + 2);
        check_eq("R7 same-cycle ack keeps result", int'(rx_status), 1);
        step(0, 0, 0, 0, 0, 1);
        idle(GAP + 1);
        // R4: cancel beats begin
        step(1, 4'd6, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0);
        check_eq("R4 cancel wins over begin", int'(queue_empty), 1);
        idle(3);
        finish_run();
    end

endmodule